// File: doc/BRIEF.md
# Interleaved Boundary-Mode Gate Controller

This block drives the two power switches of an interleaved, isolated boost-type converter whose inductors run at the edge of discontinuous conduction. Both inductor zero crossings reach the controller as one synchronous pulse stream, taken from a single shared current sense. The controller uses every other accepted pulse to restart the master switch and discards the pulse between. It measures the resulting switching period in clock cycles and starts the slave switch half a period after the master. Both switches share one on-time, set by software, so a current loop outside the block can control the drawn power through that on-time.

The on-time is stretched when needed so that each switch conducts for more than half of the measured period. The two on-times then always overlap, and the inductors always have a path to discharge. A programmable blanking window after every switching edge rejects zero-detect pulses caused by ringing. A timeout forces a master start when zero events stop arriving, which covers start-up and lost detections. Clearing the enable turns both switches off at once. The choice of which gate acts as master is fixed at the first enabled clock edge after reset.

Top module: `ibcm_gate_ctrl`

## Requirements
- R1: After reset, gate_a and gate_b are low and period reads 0.
- R2: master_sel is sampled once, at the first clock edge after reset at which en is high. The value 0 makes gate_a the master and gate_b the slave; the value 1 swaps the two roles. Later changes of master_sel have no effect until the next reset.
- R3: A zero event is accepted when zcd is high at a clock edge while en is high and blanking is not active. The first accepted event after reset or re-enable triggers the master. Every trigger causes the next accepted event to be discarded, and each discarded event lets the following one trigger again.
- R4: The master gate goes high in the cycle after the trigger edge and stays high for exactly T_eff cycles. A new trigger restarts that count.
- R5: T_eff is the larger of ton_cfg and floor(P/2)+floor(P/16)+1. P is the reference period: the cycle count measured at that trigger, or tmax_cfg for the first trigger after reset or re-enable.
- R6: At every trigger except the first after reset or re-enable, period takes the number of clock edges since the previous trigger. Between triggers it holds its value.
- R7: The slave gate goes high floor(P/2) cycles after the master's first high cycle and stays high for T_eff cycles. A trigger that arrives before the slave start cancels the pending start.
- R8: zcd is ignored for blank_cfg cycles. The window begins with the first cycle in which either switch shows a new level (rise or fall). A further edge restarts the window.
- R9: If no trigger occurs, a master trigger is forced on the tmax_cfg-th clock edge after the last trigger, or after the last edge with en low (or reset).
- R10: With en low, both gates are low in that same cycle. The edge clears the on-time counts, the pending slave start, the discard state and the timeout count. period keeps its value.
- R11: When the master's on-time ends with en high, the slave gate is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Switching enable |
| zcd | input | 1 | Synchronous zero-current event pulse, both inductors |
| master_sel | input | 1 | Master role choice: 0 = gate_a, 1 = gate_b |
| ton_cfg | input | W | Programmed on-time in clock cycles |
| blank_cfg | input | BW | Blanking length after each switch edge, in cycles |
| tmax_cfg | input | W | Timeout for a forced master start, in cycles |
| gate_a | output | 1 | Gate drive for switch A |
| gate_b | output | 1 | Gate drive for switch B |
| period | output | W | Last measured switching period, in cycles |

## Verification
The properties assume that zcd is already synchronous to clk and that tmax_cfg is small enough that the free-running cycle count never saturates. Under that assumption a stretched on-time always exceeds half the period, and the slave is on when the master ends. The stimulus keeps timeouts between 150 and 2000 cycles. It changes the on-time, blanking and timeout settings only at the start of a stimulus burst, and it holds enable low for several cycles at a time. It mixes regular zero-event trains with random ones, including dense bursts that land inside blanking windows and silent stretches that leave only the timeout to restart switching.

// File: rtl/ibcm_gate_ctrl.sv
module ibcm_gate_ctrl #(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          zcd,
  input  logic          master_sel,
  input  logic [W-1:0]  ton_cfg,
  input  logic [BW-1:0] blank_cfg,
  input  logic [W-1:0]  tmax_cfg,
  output logic          gate_a,
  output logic          gate_b,
  output logic [W-1:0]  period
);

  localparam logic [W-1:0] CNT_TOP = {W{1'b1}} - 1'b1;

  logic [W-1:0]  per_cnt, m_cnt, s_cnt, s_dly, ton_lat;
  logic [BW-1:0] blank_cnt;
  logic          skip, have_per, mst_b, sel_done, m_d, s_d;

  logic          m_on, s_on, edge_now, blanked, zok, wd, trig;
  logic [W-1:0]  meas, refp, half, lim, ton_eff;

  assign m_on     = m_cnt != '0;
  assign s_on     = s_cnt != '0;
  assign edge_now = (m_on != m_d) || (s_on != s_d);
  assign blanked  = (blank_cnt != '0) || (edge_now && blank_cfg != '0);
  assign zok      = en && zcd && !blanked;

  assign meas     = per_cnt + 1'b1;
  assign wd       = en && (meas >= tmax_cfg);
  assign trig     = en && (wd || (zok && !skip));

  assign refp     = have_per ? meas : tmax_cfg;
  assign half     = refp >> 1;
  assign lim      = half + (refp >> 4) + 1'b1;
  assign ton_eff  = (ton_cfg > lim) ? ton_cfg : lim;

  assign gate_a   = en && (mst_b ? s_on : m_on);
  assign gate_b   = en && (mst_b ? m_on : s_on);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_d       <= 1'b0;
      s_d       <= 1'b0;
      blank_cnt <= '0;
    end else begin
      m_d <= m_on;
      s_d <= s_on;
      if (edge_now)
        blank_cnt <= (blank_cfg == '0) ? '0 : blank_cfg - 1'b1;
      else if (blank_cnt != '0)
        blank_cnt <= blank_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_done <= 1'b0;
      mst_b    <= 1'b0;
    end else if (!sel_done && en) begin
      sel_done <= 1'b1;
      mst_b    <= master_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt  <= '0;
      skip     <= 1'b0;
      have_per <= 1'b0;
      period   <= '0;
      ton_lat  <= '0;
    end else if (!en) begin
      per_cnt  <= '0;
      skip     <= 1'b0;
      have_per <= 1'b0;
    end else if (trig) begin
      per_cnt  <= '0;
      skip     <= 1'b1;
      have_per <= 1'b1;
      ton_lat  <= ton_eff;
      if (have_per) period <= meas;
    end else begin
      if (per_cnt != CNT_TOP) per_cnt <= per_cnt + 1'b1;
      if (zok) skip <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0;
      s_cnt <= '0;
      s_dly <= '0;
    end else if (!en) begin
      m_cnt <= '0;
      s_cnt <= '0;
      s_dly <= '0;
    end else begin
      if (trig)      m_cnt <= ton_eff;
      else if (m_on) m_cnt <= m_cnt - 1'b1;

      if (trig)                s_dly <= half;
      else if (s_dly != '0)    s_dly <= s_dly - 1'b1;

      if (trig && half == '0)        s_cnt <= ton_eff;
      else if (!trig && s_dly == 1)  s_cnt <= ton_lat;
      else if (s_on)                 s_cnt <= s_cnt - 1'b1;
    end
  end

endmodule

module ibcm_gate_ctrl_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         m_on,
  input logic         s_on,
  input logic         trig,
  input logic         mst_b,
  input logic         sel_done,
  input logic [W-1:0] period
);

  assert_clear_on_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!m_on && !s_on));

  assert_master_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_done && $past(sel_done)) |-> $stable(mst_b));

  assert_trig_starts_master_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> m_on);

  assert_period_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> $stable(period));

  assert_overlap_at_master_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(m_on) && $past(en)) |-> s_on);

endmodule

bind ibcm_gate_ctrl ibcm_gate_ctrl_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .m_on(m_on), .s_on(s_on),
  .trig(trig), .mst_b(mst_b), .sel_done(sel_done), .period(period)
);

// File: tb/ibcm_gate_ctrl_tb_top.sv
module ibcm_gate_ctrl_tb_top;
  localparam int W  = 16;
  localparam int BW = 8;

  logic          clk = 1'b0, rst_n = 1'b0, en = 1'b0, zcd = 1'b0, msel = 1'b0;
  logic [W-1:0]  ton = 16'd40, tmax = 16'd2000;
  logic [BW-1:0] blank = 8'd4;
  logic          gate_a, gate_b;
  logic [W-1:0]  period;

  always #4 clk = ~clk;

  ibcm_gate_ctrl #(.W(W), .BW(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .zcd(zcd), .master_sel(msel),
    .ton_cfg(ton), .blank_cfg(blank), .tmax_cfg(tmax),
    .gate_a(gate_a), .gate_b(gate_b), .period(period)
  );

  int checks = 0, fails = 0;
  string tag = "R1";

  int n = 0, e_done = 0, e_mst = 0, e_skip = 0, e_have = 0, tref = 0, e_per = 0;
  int ms = -1000, mton = 0, ss = -1000, ston = 0, pend = -1, pton = 0;
  int last_e = -1000, pgm = 0, pgs = 0, exp_a = 0, exp_b = 0;
  bit prev_mp = 1'b0;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at edge %0d: actual %0d expected %0d", tag, what, n, act, exp);
    end
  endtask

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic model_step();
    int e_en, ign, zok, meas, wd, trg, p, h, t, gm, gs;
    n++;
    e_en = int'(en);
    ign  = ((n - 1 - last_e) < int'(blank)) ? 1 : 0;
    zok  = (e_en != 0 && zcd && ign == 0) ? 1 : 0;
    meas = n - tref;
    wd   = (e_en != 0 && meas >= int'(tmax)) ? 1 : 0;
    trg  = (e_en != 0 && (wd != 0 || (zok != 0 && e_skip == 0))) ? 1 : 0;
    if (e_done == 0 && e_en != 0) begin e_done = 1; e_mst = int'(msel); end
    if (e_en == 0) begin
      tref = n; e_skip = 0; e_have = 0; mton = 0; ston = 0; pend = -1;
    end else begin
      if (trg != 0) begin
        p = (e_have != 0) ? meas : int'(tmax);
        h = p / 2;
        t = imax(int'(ton), h + p / 16 + 1);
        if (e_have != 0) e_per = meas;
        e_have = 1; e_skip = 1; tref = n;
        ms = n; mton = t; pend = n + h; pton = t;
      end else if (zok != 0) e_skip = 0;
      if (pend == n) begin ss = n; ston = pton; pend = -1; end
    end
    gm = (n >= ms && n < ms + mton) ? 1 : 0;
    gs = (n >= ss && n < ss + ston) ? 1 : 0;
    if (gm != pgm || gs != pgs) last_e = n;
    pgm = gm; pgs = gs;
    exp_a = (e_en != 0) ? ((e_mst != 0) ? gs : gm) : 0;
    exp_b = (e_en != 0) ? ((e_mst != 0) ? gm : gs) : 0;
  endtask

  task automatic cyc();
    bit mp, sp;
    @(posedge clk);
    @(negedge clk);
    model_step();
    chk("gate_a", int'(gate_a), exp_a);
    chk("gate_b", int'(gate_b), exp_b);
    chk("period", int'(period), e_per);
    mp = (e_mst != 0) ? gate_b : gate_a;
    sp = (e_mst != 0) ? gate_a : gate_b;
    if (en && prev_mp && !mp) begin
      checks++;
      if (!sp) begin
        fails++;
        $display("FAIL R11 slave low at master end, edge %0d: actual %0b expected 1", n, sp);
      end
    end
    prev_mp = mp;
  endtask

  task automatic run(int cnt, int zper, int zoff);
    for (int i = 0; i < cnt; i++) begin
      zcd = (zper > 0) && ((i % zper) == zoff);
      cyc();
    end
    zcd = 1'b0;
  endtask

  task automatic rnd(int cnt);
    for (int i = 0; i < cnt; i++) begin
      if (i % 2000 == 0) begin
        ton   = W'(1 + $urandom % 300);
        blank = BW'($urandom % 21);
        tmax  = W'(200 + $urandom % 600);
        msel  = 1'($urandom % 2);
      end
      if ($urandom % 3000 == 0) begin
        en = 1'b0; zcd = 1'b0;
        for (int k = 0; k < 5; k++) cyc();
        en = 1'b1;
      end
      zcd = ($urandom % 40) == 0;
      cyc();
    end
    zcd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("gate_a", int'(gate_a), 0);
    chk("gate_b", int'(gate_b), 0);
    chk("period", int'(period), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("gate_a", int'(gate_a), 0);

    tag = "R2 R3 R4 R7";
    en = 1'b1; msel = 1'b1; ton = 16'd40; blank = 8'd4; tmax = 16'd2000;
    run(1500, 50, 0);
    tag = "R2";
    msel = 1'b0;
    run(600, 50, 0);

    tag = "R5";
    ton = 16'd5;
    run(1200, 60, 0);
    tag = "R4 R5";
    ton = 16'd200;
    run(800, 60, 0);

    tag = "R8";
    ton = 16'd30; blank = 8'd25;
    run(1500, 7, 0);
    blank = 8'd0;
    run(600, 9, 3);

    tag = "R9";
    blank = 8'd4; ton = 16'd60; tmax = 16'd150;
    run(1000, 0, 0);

    tag = "R10";
    tmax = 16'd500; ton = 16'd40;
    for (int r = 0; r < 4; r++) begin
      en = 1'b0;
      run(12, 50, 0);
      en = 1'b1;
      run(300 + 17 * r, 37, 5);
    end

    tag = "R6 R9 R10";
    rnd(20000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule